// File: doc/BRIEF.md
# Carrier-Gap Downlink Frame Encoder

This block turns a single command request into a downlink frame for a 125 kHz read/write transponder and plays that frame out on one field-enable line. The request is a 2-bit command selector, a 6-bit word address and a 32-bit data word, all sampled when `start` is accepted. The encoder puts together the frame bits (two leading zeros, a 4-bit command code, an address with parity where the command needs one, and a parity-protected data matrix where the command needs one). It then sends each bit as a pattern of field-on and field-off intervals whose lengths are counted in carrier cycles.

Carrier cycles reach the block as a one-clock strobe, `tick`, so the system clock can run at any rate above the carrier. When a frame is accepted, the field first stays on for a long settle interval so the transponder can power up. A long opening gap stands in for the first bit. Every later bit is either a plain on interval (a one) or a short gap followed by a short on interval (a zero). `busy` covers the whole frame. `done` pulses once when the last on interval ends, and the field stays on after that.

Top module: `flink_fwd_encoder`

## Requirements
- R1: During and right after reset, `field_en`, `busy` and `done` are all low.
- R2: A `start` sampled while idle raises `busy` and `field_en` at that edge. The field then stays on for SETTLE_TICKS ticks.
- R3: After the settle interval, the first frame bit is always sent as FIRST_OFF_TICKS (default 55) ticks with the field off, then FIRST_ON_TICKS (default 16) ticks with it on, whatever the bit's value.
- R4: Each later bit value 1 keeps the field on for ONE_ON_TICKS (32) ticks. Each later bit value 0 turns it off for ZERO_OFF_TICKS (23) ticks, then on for ZERO_ON_TICKS (9) ticks.
- R5: Every frame starts with two 0 bits, then a 4-bit command code sent LSB first. The codes by `cmd_sel` are: 0 login = 0xC, 1 read = 0x9, 2 write = 0xA, 3 disable = 0x5.
- R6: The address field is `addr` sent LSB first (6 bits), followed by one bit that is the XOR of those 6 bits.
- R7: The data field has 45 bits. First come the four bytes of `data`, starting with bits 7:0 and ending with bits 31:24; each byte is sent LSB first and is followed by its XOR parity bit. Then come 8 column-parity bits, where column j is the XOR of bit j of the four bytes, sent for j = 0 first. A single 0 bit closes the field.
- R8: Frame contents by command: login = head + data (51 bits), read = head + address (13 bits), write = head + address + data (58 bits), disable = head only (6 bits).
- R9: `done` is a one-cycle pulse. It is raised at the edge where the last bit's on interval ends. `busy` falls at that same edge, and `field_en` stays high afterwards.
- R10: A `start` that arrives while `busy` is high is ignored, and the frame in flight is not changed.
- R11: Intervals advance only on cycles where `tick` is high. `field_en` changes only at an edge where `tick` or an accepted `start` was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per carrier cycle |
| start | input | 1 | Request to send a frame (accepted when idle) |
| cmd_sel | input | 2 | Command: 0 login, 1 read, 2 write, 3 disable |
| addr | input | 6 | Word address for read and write |
| data | input | 32 | Data word for login and write |
| field_en | output | 1 | Carrier field enable (1 = field on) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame completes |

## Verification
The bench builds the encoder with the settle interval cut down to 40 ticks and keeps the default bit-interval lengths. This lets it run all four commands, including the full 58-bit write frame, many times within a short run while the gap timings stay the real ones. The tick strobe comes on every cycle, every third cycle, or in an irregular pattern. This shows that interval lengths follow the strobe and not the clock. The data words are chosen so that row and column parities take both values. One frame also receives a second `start` while it is in flight.

// File: rtl/flink_pkg.sv
package flink_pkg;

  typedef enum logic [1:0] {
    CMD_LOGIN   = 2'd0,
    CMD_READ    = 2'd1,
    CMD_WRITE   = 2'd2,
    CMD_DISABLE = 2'd3
  } flink_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOW    = 2'd2,
    ST_HIGH   = 2'd3
  } flink_state_e;

  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 32;
  localparam int HEAD_W    = 6;
  localparam int AFIELD_W  = ADDR_W + 1;
  localparam int DFIELD_W  = 45;
  localparam int FRAME_W   = 64;
  localparam int IDX_W     = $clog2(FRAME_W);
  localparam int LEN_W     = IDX_W + 1;

  function automatic logic [3:0] cmd_code(flink_cmd_e c);
    case (c)
      CMD_LOGIN: cmd_code = 4'hC;
      CMD_READ:  cmd_code = 4'h9;
      CMD_WRITE: cmd_code = 4'hA;
      default:   cmd_code = 4'h5;
    endcase
  endfunction

endpackage

// File: rtl/flink_frame_build.sv
module flink_frame_build
  import flink_pkg::*;
(
  input  flink_cmd_e                cmd,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         data,
  output logic [FRAME_W-1:0]        frame,
  output logic [LEN_W-1:0]          len
);

  localparam int BYTES = DATA_W / 8;
  localparam int ROW_W = 9;

  logic [DFIELD_W-1:0] dfield;
  logic [AFIELD_W-1:0] afield;
  logic [HEAD_W-1:0]   head;
  logic                has_addr;
  logic                has_data;

  genvar g, j;
  generate
    for (g = 0; g < BYTES; g++) begin : g_row
      assign dfield[g*ROW_W +: 8]  = data[g*8 +: 8];
      assign dfield[g*ROW_W + 8]   = ^data[g*8 +: 8];
    end
    for (j = 0; j < 8; j++) begin : g_col
      assign dfield[BYTES*ROW_W + j] = data[j] ^ data[8+j] ^ data[16+j] ^ data[24+j];
    end
  endgenerate
  assign dfield[DFIELD_W-1] = 1'b0;

  assign afield   = {^addr, addr};
  assign head     = {cmd_code(cmd), 2'b00};
  assign has_addr = (cmd == CMD_READ) || (cmd == CMD_WRITE);
  assign has_data = (cmd == CMD_LOGIN) || (cmd == CMD_WRITE);

  always_comb begin
    frame = FRAME_W'(head);
    if (has_addr)
      frame = frame | (FRAME_W'(afield) << HEAD_W);
    if (has_data)
      frame = frame | (FRAME_W'(dfield) << (has_addr ? HEAD_W + AFIELD_W : HEAD_W));
    len = LEN_W'(HEAD_W)
        + (has_addr ? LEN_W'(AFIELD_W) : '0)
        + (has_data ? LEN_W'(DFIELD_W) : '0);
  end

endmodule

// File: rtl/flink_tick_cnt.sv
module flink_tick_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] dur,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  assign expire = en && tick && (cnt_q == dur - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clear || expire)
      cnt_q <= '0;
    else if (en && tick)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/flink_fwd_encoder.sv
module flink_fwd_encoder
  import flink_pkg::*;
#(
  parameter int SETTLE_TICKS    = 18750,
  parameter int FIRST_OFF_TICKS = 55,
  parameter int FIRST_ON_TICKS  = 16,
  parameter int ONE_ON_TICKS    = 32,
  parameter int ZERO_OFF_TICKS  = 23,
  parameter int ZERO_ON_TICKS   = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        start,
  input  logic [1:0]  cmd_sel,
  input  logic [5:0]  addr,
  input  logic [31:0] data,
  output logic        field_en,
  output logic        busy,
  output logic        done
);

  localparam int MAX_A   = (SETTLE_TICKS > FIRST_OFF_TICKS) ? SETTLE_TICKS : FIRST_OFF_TICKS;
  localparam int MAX_B   = (ONE_ON_TICKS > ZERO_OFF_TICKS) ? ONE_ON_TICKS : ZERO_OFF_TICKS;
  localparam int MAX_DUR = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  flink_state_e        state_q;
  logic [FRAME_W-1:0]  frame_d, frame_q;
  logic [LEN_W-1:0]    len_d, len_q;
  logic [LEN_W-1:0]    idx_q, nxt_idx;
  logic [CNT_W-1:0]    dur_q;
  logic                expire;
  logic                start_acc;
  logic                last_bit;
  logic                nxt_bit;

  flink_frame_build u_build (
    .cmd   (flink_cmd_e'(cmd_sel)),
    .addr  (addr),
    .data  (data),
    .frame (frame_d),
    .len   (len_d)
  );

  flink_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en     (state_q != ST_IDLE),
    .tick   (tick),
    .clear  (start_acc),
    .dur    (dur_q),
    .expire (expire)
  );

  assign start_acc = start && (state_q == ST_IDLE);
  assign last_bit  = (idx_q == len_q - 1'b1);
  assign nxt_idx   = idx_q + 1'b1;
  assign nxt_bit   = frame_q[nxt_idx[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      frame_q  <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      dur_q    <= '0;
      field_en <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        frame_q  <= frame_d;
        len_q    <= len_d;
        idx_q    <= '0;
        dur_q    <= CNT_W'(SETTLE_TICKS);
        state_q  <= ST_SETTLE;
        field_en <= 1'b1;
        busy     <= 1'b1;
      end else if (expire) begin
        case (state_q)
          ST_SETTLE: begin
            state_q  <= ST_LOW;
            dur_q    <= CNT_W'(FIRST_OFF_TICKS);
            field_en <= 1'b0;
          end
          ST_LOW: begin
            state_q  <= ST_HIGH;
            dur_q    <= (idx_q == '0) ? CNT_W'(FIRST_ON_TICKS) : CNT_W'(ZERO_ON_TICKS);
            field_en <= 1'b1;
          end
          ST_HIGH: begin
            if (last_bit) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
            end else begin
              idx_q <= nxt_idx;
              if (nxt_bit) begin
                state_q <= ST_HIGH;
                dur_q   <= CNT_W'(ONE_ON_TICKS);
              end else begin
                state_q  <= ST_LOW;
                dur_q    <= CNT_W'(ZERO_OFF_TICKS);
                field_en <= 1'b0;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/flink_fwd_encoder_chk.sv
module flink_fwd_encoder_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic start,
  input logic field_en,
  input logic busy,
  input logic done
);

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: completion leaves the block idle with the field on
  a_r9_done_idle_field: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && field_en));

  // R9: busy only drops together with done
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R2: a frame opens with the field on, caused by a start
  a_r2_open_on: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (field_en && $past(start)));

  // R11: field moves only after a tick or an accepted start
  a_r11_field_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_en) |-> ($past(tick) || $past(start)));

  // R10: a start while busy does not end or restart the frame
  a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick) |=> busy);

endmodule

bind flink_fwd_encoder flink_fwd_encoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .start    (start),
  .field_en (field_en),
  .busy     (busy),
  .done     (done)
);

// File: tb/flink_fwd_encoder_tb.sv
module flink_fwd_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 40;
  localparam int F_OFF      = 55;
  localparam int F_ON       = 16;
  localparam int ONE_ON     = 32;
  localparam int Z_OFF      = 23;
  localparam int Z_ON       = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd_sel = 2'd0;
  logic [5:0]  addr = 6'd0;
  logic [31:0] data = 32'd0;
  logic        field_en, busy, done;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    tick_mode = 0;
  int    cyc = 0;
  int    wd = 0;
  bit    chk_en = 1'b0;
  bit    finished = 1'b0;
  string run_tag = "R1";

  // reference model state
  int q_lvl[$];
  int q_rem[$];
  bit m_busy = 1'b0;
  bit m_done = 1'b0;
  bit m_field = 1'b0;

  flink_fwd_encoder #(
    .SETTLE_TICKS   (SETTLE),
    .FIRST_OFF_TICKS(F_OFF),
    .FIRST_ON_TICKS (F_ON),
    .ONE_ON_TICKS   (ONE_ON),
    .ZERO_OFF_TICKS (Z_OFF),
    .ZERO_ON_TICKS  (Z_ON)
  ) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .start(start),
    .cmd_sel(cmd_sel), .addr(addr), .data(data),
    .field_en(field_en), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // frame bits as the requirements describe them (R5 R6 R7 R8)
  function automatic void build_segments(int sel, logic [5:0] a, logic [31:0] d);
    int bits[$];
    int code;
    int p;
    bits.push_back(0);
    bits.push_back(0);
    case (sel)
      0: code = 'hC;
      1: code = 'h9;
      2: code = 'hA;
      default: code = 'h5;
    endcase
    for (int i = 0; i < 4; i++) bits.push_back((code >> i) & 1);
    if (sel == 1 || sel == 2) begin
      p = 0;
      for (int i = 0; i < 6; i++) begin bits.push_back(int'(a[i])); p ^= int'(a[i]); end
      bits.push_back(p);
    end
    if (sel == 0 || sel == 2) begin
      for (int g = 0; g < 4; g++) begin
        p = 0;
        for (int b = 0; b < 8; b++) begin bits.push_back(int'(d[g*8+b])); p ^= int'(d[g*8+b]); end
        bits.push_back(p);
      end
      for (int jj = 0; jj < 8; jj++) begin
        p = 0;
        for (int g = 0; g < 4; g++) p ^= int'(d[g*8+jj]);
        bits.push_back(p);
      end
      bits.push_back(0);
    end
    q_lvl.push_back(1); q_rem.push_back(SETTLE);
    q_lvl.push_back(0); q_rem.push_back(F_OFF);
    q_lvl.push_back(1); q_rem.push_back(F_ON);
    for (int k = 1; k < bits.size(); k++) begin
      if (bits[k] == 1) begin
        q_lvl.push_back(1); q_rem.push_back(ONE_ON);
      end else begin
        q_lvl.push_back(0); q_rem.push_back(Z_OFF);
        q_lvl.push_back(1); q_rem.push_back(Z_ON);
      end
    end
  endfunction

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (rst) begin
      q_lvl.delete(); q_rem.delete();
      m_busy = 1'b0; m_done = 1'b0; m_field = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        if (tick) begin
          q_rem[0] = q_rem[0] - 1;
          if (q_rem[0] == 0) begin
            void'(q_lvl.pop_front());
            void'(q_rem.pop_front());
            if (q_lvl.size() == 0) begin
              m_busy = 1'b0;
              m_done = 1'b1;
              m_field = 1'b1;
            end else begin
              m_field = q_lvl[0][0];
            end
          end
        end
      end else if (start) begin
        build_segments(int'(cmd_sel), addr, data);
        m_busy = 1'b1;
        m_field = q_lvl[0][0];
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (chk_en && !rst) begin
      check({run_tag, " field_en (R2 R3 R4 R11)"}, int'(field_en), int'(m_field));
      check("R9 busy", int'(busy), int'(m_busy));
      check("R9 done", int'(done), int'(m_done));
    end
  end

  // carrier strobe patterns
  always @(negedge clk) begin
    cyc++;
    case (tick_mode)
      0: tick <= 1'b1;
      1: tick <= (cyc % 3 == 0);
      default: tick <= ((cyc % 5) == 0) || ((cyc % 5) == 1) || ((cyc % 7) == 3);
    endcase
  end

  // watchdog
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected below %0d", wd, 150000);
      report();
    end
  end

  task automatic send(int sel, logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    cmd_sel = 2'(sel);
    addr    = a;
    data    = d;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 field_en", int'(field_en), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 field_en after release", int'(field_en), 0);
    chk_en = 1'b1;

    tick_mode = 1; run_tag = "R7 login";
    send(0, 6'h00, 32'hA5C3_0F81);
    wait_idle();

    tick_mode = 0; run_tag = "R6 read";
    send(1, 6'h2D, 32'h0);
    wait_idle();
    send(1, 6'h3F, 32'hFFFF_FFFF);
    wait_idle();

    tick_mode = 1; run_tag = "R8 write";
    send(2, 6'h15, 32'h1234_5678);
    wait_idle();

    tick_mode = 0; run_tag = "R5 disable";
    send(3, 6'h0A, 32'hDEAD_BEEF);
    wait_idle();

    tick_mode = 2; run_tag = "R10 restart ignored";
    send(2, 6'h01, 32'h8000_0001);
    repeat (300) @(negedge clk);
    send(3, 6'h3C, 32'h0F0F_F0F0);
    repeat (10) @(negedge clk);
    data = 32'h0; addr = 6'h0;
    wait_idle();

    tick_mode = 2; run_tag = "R11 irregular tick";
    send(0, 6'h00, 32'hFFFF_0000);
    wait_idle();
    send(3, 6'h00, 32'h0);
    wait_idle();

    chk_en = 1'b0;
    report();
  end

endmodule